// File: doc/BRIEF.md
# Slave Configuration Port Activation Detector

While the active-low configuration reset pin is held low, this block watches the two pin-shared slave configuration ports and decides whether an external master has claimed configuration access. A claim is a fixed 32-bit key. On the SPI side the key is shifted in through a built-in mode-0 receiver. On the I2C side the key comes as byte strobes from a separate I2C slave front end, which also reports when a write to the configuration address has been seen.

The first port whose key matches wins and locks the other port out. When the reset pin is released, a winning port keeps its active flag, which puts the device into slave configuration. If no port won, the block raises a request for the master auto-boot sequence. At power-up, a claim counts only inside a window of cycles measured from power-good. A high-to-low transition of the reset pin (a refresh) or a loss of power-good clears the decision.

Top module: `cfg_act_detect`

## Requirements
- R1: The key is 0xA4C6F48A, sent most-significant byte first (A4, C6, F4, 8A), and all 32 bits must match. A key with any bit different activates nothing.
- R2: SPI uses mode 0: the receiver samples MOSI on the rising SCK edge, MSB first, while CSN is low. The first byte of a CSN-low frame is always a dummy. Further bytes also count as dummies until one equals 0xA4, which starts the key. A frame with at least one dummy byte followed by the four key bytes activates SPI. A mismatch inside the key, or a key split across two frames, activates nothing until CSN rises.
- R3: On I2C, the four key bytes must follow a configuration-address-write strobe (7-bit or 10-bit addressing is decoded upstream). A stop strobe, a wrong byte, or key bytes with no preceding address strobe activate nothing. A correct key activates I2C two clock edges after the final byte strobe is sampled.
- R4: After power-up, a key is accepted only while fewer than WIN_CYCLES clocks have passed since power-good rose. After a refresh, this window no longer applies.
- R5: A key is accepted only while the synchronised cfg_rst_n is low. A key that arrives while it is high changes no output.
- R6: When cfg_rst_n rises, an active port keeps its flag. If no port is active, boot_req asserts instead.
- R7: The first port to activate locks the other (spi_locked or i2c_locked = 1). Traffic on the locked port has no effect, even if its key was partly received before the lock.
- R8: A high-to-low transition of cfg_rst_n clears all flags. Power-good low clears all flags and withdraws the refresh exemption.
- R9: After reset, all five outputs are 0. At most one of slv_spi_act, slv_i2c_act and boot_req is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the SPI clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply good; window counting starts when it rises |
| cfg_rst_n | input | 1 | Active-low configuration reset pin (asynchronous) |
| spi_sck | input | 1 | SPI clock pin (asynchronous) |
| spi_csn | input | 1 | SPI chip select, active low (asynchronous) |
| spi_mosi | input | 1 | SPI data in (asynchronous) |
| i2c_addr_hit | input | 1 | One-cycle strobe: address write to the configuration address |
| i2c_byte_vld | input | 1 | One-cycle strobe: i2c_byte holds a received data byte |
| i2c_byte | input | 8 | Received I2C data byte |
| i2c_stop | input | 1 | One-cycle strobe: stop condition seen |
| slv_spi_act | output | 1 | SPI port has claimed slave configuration |
| slv_i2c_act | output | 1 | I2C port has claimed slave configuration |
| boot_req | output | 1 | Master auto-boot requested |
| spi_locked | output | 1 | SPI port locked out |
| i2c_locked | output | 1 | I2C port locked out |

## Verification
An I2C activation is due exactly two clock edges after the last key strobe is sampled. The bench checks the flag is still low at the negative edge after the first of these and high at the next. An SPI activation comes about four clocks after the system clock samples the final rising SCK: two synchroniser stages, the matcher register and the arbiter register. The bench holds SCK low for four clocks and CSN high for eight more before it samples. The reset pin goes through two synchroniser flops and one edge register, so a boot request or a clear is due three edges after the pin moves. The bench waits six cycles before it looks.

// File: rtl/cfg_act_pkg.sv
package cfg_act_pkg;

    localparam logic [31:0] ACT_KEY   = 32'hA4C6F48A;
    localparam int          KEY_BYTES = 4;

    typedef enum logic [1:0] {
        PM_IDLE,
        PM_SPI,
        PM_I2C,
        PM_BOOT
    } port_mode_e;

    typedef enum logic [2:0] {
        SM_FIRST,
        SM_DUMMY,
        SM_KEY,
        SM_FAIL,
        SM_DONE
    } spi_match_e;

    typedef struct packed {
        logic spi;
        logic i2c;
    } port_pair_t;

    function automatic logic [7:0] key_byte(input logic [1:0] idx);
        return ACT_KEY[(31 - 8 * int'(idx)) -: 8];
    endfunction

endpackage

// File: rtl/cfg_act_sync.sv
module cfg_act_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[g];
                s2 <= RST_VAL[g];
            end else begin
                s1 <= din[g];
                s2 <= s1;
            end
        end
        assign dout[g] = s2;
    end
endmodule

// File: rtl/cfg_act_spi_key.sv
module cfg_act_spi_key
    import cfg_act_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic sck_s,
    input  logic csn_s,
    input  logic mosi_s,
    output logic hit
);
    logic       sck_d;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;
    logic [1:0] idx;
    spi_match_e st;
    logic       hit_q;
    logic       sck_rise;
    logic [7:0] byte_w;

    assign sck_rise = sck_s & ~sck_d;
    assign byte_w   = {shreg, mosi_s};

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= sck_s;
    end

    always_ff @(posedge clk) begin
        if (rst || hold || csn_s) begin
            bit_cnt <= '0;
            shreg   <= '0;
            idx     <= '0;
            st      <= SM_FIRST;
            hit_q   <= 1'b0;
        end else begin
            hit_q <= 1'b0;
            if (sck_rise) begin
                shreg   <= byte_w[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    case (st)
                        SM_FIRST: st <= SM_DUMMY;
                        SM_DUMMY: begin
                            if (byte_w == key_byte(2'd0)) begin
                                st  <= SM_KEY;
                                idx <= 2'd1;
                            end
                        end
                        SM_KEY: begin
                            if (byte_w == key_byte(idx)) begin
                                if (idx == 2'(KEY_BYTES - 1)) begin
                                    hit_q <= 1'b1;
                                    st    <= SM_DONE;
                                end else begin
                                    idx <= idx + 2'd1;
                                end
                            end else begin
                                st <= SM_FAIL;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign hit = hit_q;

    assert_frame_low_R2: assert property (@(posedge clk) disable iff (rst)
        hit_q |-> $past(!csn_s && !hold));

endmodule

// File: rtl/cfg_act_i2c_key.sv
module cfg_act_i2c_key
    import cfg_act_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       addr_hit,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       stop,
    output logic       hit
);
    logic       armed;
    logic [1:0] idx;
    logic       hit_q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            armed <= 1'b0;
            idx   <= '0;
            hit_q <= 1'b0;
        end else begin
            hit_q <= 1'b0;
            if (stop) begin
                armed <= 1'b0;
            end else if (addr_hit) begin
                armed <= 1'b1;
                idx   <= '0;
            end else if (byte_vld && armed) begin
                if (byte_in == key_byte(idx)) begin
                    if (idx == 2'(KEY_BYTES - 1)) begin
                        hit_q <= 1'b1;
                        armed <= 1'b0;
                    end else begin
                        idx <= idx + 2'd1;
                    end
                end else begin
                    armed <= 1'b0;
                end
            end
        end
    end

    assign hit = hit_q;

    assert_after_addr_R3: assert property (@(posedge clk) disable iff (rst)
        hit_q |-> $past(byte_vld && armed));

endmodule

// File: rtl/cfg_act_arb.sv
module cfg_act_arb
    import cfg_act_pkg::*;
#(
    parameter int WIN_CYCLES = 1_900_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_good,
    input  logic       rstn_s,
    input  port_pair_t hits,
    output port_mode_e mode
);
    localparam int CW = $clog2(WIN_CYCLES + 1);

    logic [CW-1:0] win_cnt;
    logic          win_open;
    logic          refreshed_q;
    logic          rstn_d;
    logic          fall, rise;
    port_mode_e    mode_q;

    assign win_open = win_cnt < CW'(WIN_CYCLES);
    assign fall     = rstn_d & ~rstn_s;
    assign rise     = ~rstn_d & rstn_s;

    always_ff @(posedge clk) begin
        if (rst || !pwr_good)               win_cnt <= '0;
        else if (win_cnt != CW'(WIN_CYCLES)) win_cnt <= win_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rstn_d      <= 1'b0;
            refreshed_q <= 1'b0;
            mode_q      <= PM_IDLE;
        end else begin
            rstn_d <= rstn_s;
            if (!pwr_good) begin
                mode_q      <= PM_IDLE;
                refreshed_q <= 1'b0;
            end else if (fall) begin
                mode_q      <= PM_IDLE;
                refreshed_q <= 1'b1;
            end else if (mode_q == PM_IDLE) begin
                if (!rstn_s && (win_open || refreshed_q)) begin
                    if (hits.spi)      mode_q <= PM_SPI;
                    else if (hits.i2c) mode_q <= PM_I2C;
                end else if (rise) begin
                    mode_q <= PM_BOOT;
                end
            end
        end
    end

    assign mode = mode_q;

    assert_window_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_IDLE && !refreshed_q && !win_open)
        |=> (mode_q != PM_SPI && mode_q != PM_I2C));

    assert_only_low_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_IDLE && rstn_s) |=> (mode_q != PM_SPI && mode_q != PM_I2C));

    assert_boot_on_release_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_IDLE && rise && pwr_good) |=> mode_q == PM_BOOT);

    assert_spi_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_SPI && pwr_good && !fall) |=> mode_q == PM_SPI);

    assert_i2c_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == PM_I2C && pwr_good && !fall) |=> mode_q == PM_I2C);

    assert_refresh_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (fall || !pwr_good) |=> mode_q == PM_IDLE);

endmodule

// File: rtl/cfg_act_detect.sv
module cfg_act_detect
    import cfg_act_pkg::*;
#(
    parameter int WIN_CYCLES = 1_900_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_good,
    input  logic       cfg_rst_n,
    input  logic       spi_sck,
    input  logic       spi_csn,
    input  logic       spi_mosi,
    input  logic       i2c_addr_hit,
    input  logic       i2c_byte_vld,
    input  logic [7:0] i2c_byte,
    input  logic       i2c_stop,
    output logic       slv_spi_act,
    output logic       slv_i2c_act,
    output logic       boot_req,
    output logic       spi_locked,
    output logic       i2c_locked
);
    logic [3:0] pins_s;
    port_pair_t hits;
    port_mode_e mode;

    cfg_act_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({cfg_rst_n, spi_csn, spi_mosi, spi_sck}),
        .dout (pins_s)
    );

    cfg_act_spi_key u_spi (
        .clk    (clk),
        .rst    (rst),
        .hold   (mode == PM_I2C),
        .sck_s  (pins_s[0]),
        .csn_s  (pins_s[2]),
        .mosi_s (pins_s[1]),
        .hit    (hits.spi)
    );

    cfg_act_i2c_key u_i2c (
        .clk      (clk),
        .rst      (rst),
        .hold     (mode == PM_SPI),
        .addr_hit (i2c_addr_hit),
        .byte_vld (i2c_byte_vld),
        .byte_in  (i2c_byte),
        .stop     (i2c_stop),
        .hit      (hits.i2c)
    );

    cfg_act_arb #(.WIN_CYCLES(WIN_CYCLES)) u_arb (
        .clk      (clk),
        .rst      (rst),
        .pwr_good (pwr_good),
        .rstn_s   (pins_s[3]),
        .hits     (hits),
        .mode     (mode)
    );

    assign slv_spi_act = (mode == PM_SPI);
    assign slv_i2c_act = (mode == PM_I2C);
    assign boot_req    = (mode == PM_BOOT);
    assign spi_locked  = (mode == PM_I2C);
    assign i2c_locked  = (mode == PM_SPI);

endmodule

// File: tb/cfg_act_detect_test.sv
`timescale 1ns/1ps
module cfg_act_detect_test;
    localparam int WIN = 4000;

    logic clk = 1'b0;
    logic rst, pwr_good, cfg_rst_n, spi_sck, spi_csn, spi_mosi;
    logic i2c_addr_hit, i2c_byte_vld, i2c_stop;
    logic [7:0] i2c_byte;
    logic slv_spi_act, slv_i2c_act, boot_req, spi_locked, i2c_locked;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cfg_act_detect #(.WIN_CYCLES(WIN)) uut (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .cfg_rst_n(cfg_rst_n),
        .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
        .i2c_addr_hit(i2c_addr_hit), .i2c_byte_vld(i2c_byte_vld),
        .i2c_byte(i2c_byte), .i2c_stop(i2c_stop),
        .slv_spi_act(slv_spi_act), .slv_i2c_act(slv_i2c_act), .boot_req(boot_req),
        .spi_locked(spi_locked), .i2c_locked(i2c_locked)
    );

    // order: spi_act, i2c_act, boot, spi_locked, i2c_locked
    task automatic chk(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {slv_spi_act, slv_i2c_act, boot_req, spi_locked, i2c_locked};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_frame(input logic [63:0] d, input int nbytes);
        spi_csn = 1'b0;
        wait_clk(4);
        for (int i = 0; i < nbytes * 8; i++) begin
            spi_mosi = d[nbytes * 8 - 1 - i];
            wait_clk(4);
            spi_sck = 1'b1;
            wait_clk(4);
            spi_sck = 1'b0;
        end
        wait_clk(4);
        spi_csn = 1'b1;
        wait_clk(8);
    endtask

    task automatic i2c_pulse_addr;
        i2c_addr_hit = 1'b1; wait_clk(1); i2c_addr_hit = 1'b0; wait_clk(1);
    endtask

    task automatic i2c_pulse_stop;
        i2c_stop = 1'b1; wait_clk(1); i2c_stop = 1'b0; wait_clk(1);
    endtask

    // ends right after the strobe is withdrawn (one edge after it was sampled)
    task automatic i2c_pulse_byte(input logic [7:0] b);
        i2c_byte = b; i2c_byte_vld = 1'b1; wait_clk(1); i2c_byte_vld = 1'b0;
    endtask

    task automatic i2c_key(input bit with_addr, input int stop_at, input logic [31:0] k);
        if (with_addr) i2c_pulse_addr();
        for (int b = 0; b < 4; b++) begin
            if (b == stop_at) i2c_pulse_stop();
            i2c_pulse_byte(k[31 - 8 * b -: 8]);
            if (b != 3) wait_clk(1);
        end
        wait_clk(2);
    endtask

    task automatic refresh;
        cfg_rst_n = 1'b1; wait_clk(6);
        cfg_rst_n = 1'b0; wait_clk(6);
    endtask

    task automatic t_reset;
        chk("R9 reset state", 5'b00000);
    endtask

    task automatic t_spi_rejects;
        spi_frame({24'h0, 8'h00, 32'hA4C6F48B}, 5);
        chk("R1 spi key one bit off", 5'b00000);
        spi_frame({32'h0, 32'hA4C6F48A}, 4);
        chk("R2 spi key without dummy", 5'b00000);
        spi_frame({40'h0, 8'h00, 16'hA4C6}, 3);
        spi_frame({48'h0, 16'hF48A}, 2);
        chk("R2 spi key split over frames", 5'b00000);
    endtask

    task automatic t_i2c_rejects;
        i2c_key(1'b1, 2, 32'hA4C6F48A);
        chk("R3 i2c stop mid key", 5'b00000);
        i2c_key(1'b0, 4, 32'hA4C6F48A);
        chk("R3 i2c key without address", 5'b00000);
        i2c_key(1'b1, 4, 32'h24C6F48A);
        chk("R1 i2c key wrong msb", 5'b00000);
    endtask

    task automatic t_spi_multi_dummy;
        spi_frame({16'h0, 8'h00, 8'hFF, 32'hA4C6F48A}, 6);
        chk("R2 spi two dummies then key", 5'b10001);
        cfg_rst_n = 1'b1; wait_clk(6);
        chk("R6 release keeps spi active", 5'b10001);
        cfg_rst_n = 1'b0; wait_clk(6);
        chk("R8 refresh clears spi", 5'b00000);
    endtask

    task automatic t_i2c_ok;
        i2c_pulse_addr();
        i2c_pulse_byte(8'hA4); wait_clk(1);
        i2c_pulse_byte(8'hC6); wait_clk(1);
        i2c_pulse_byte(8'hF4); wait_clk(1);
        i2c_pulse_byte(8'h8A);
        chk("R3 i2c flag not yet due", 5'b00000);
        wait_clk(1);
        chk("R3 i2c active on second edge", 5'b01010);
        refresh();
        chk("R8 refresh clears i2c", 5'b00000);
    endtask

    task automatic t_lockout;
        i2c_pulse_addr();
        i2c_pulse_byte(8'hA4); wait_clk(1);
        i2c_pulse_byte(8'hC6); wait_clk(1);
        spi_frame({24'h0, 8'h5A, 32'hA4C6F48A}, 5);
        chk("R7 spi wins and locks i2c", 5'b10001);
        i2c_pulse_byte(8'hF4); wait_clk(1);
        i2c_pulse_byte(8'h8A); wait_clk(3);
        chk("R7 locked i2c tail ignored", 5'b10001);
        i2c_key(1'b1, 4, 32'hA4C6F48A);
        chk("R7 full i2c key ignored", 5'b10001);
        refresh();
    endtask

    task automatic t_boot;
        cfg_rst_n = 1'b1; wait_clk(6);
        chk("R6 release with no port boots", 5'b00100);
        i2c_key(1'b1, 4, 32'hA4C6F48A);
        spi_frame({24'h0, 8'h00, 32'hA4C6F48A}, 5);
        chk("R5 key while reset high ignored", 5'b00100);
    endtask

    task automatic t_window;
        pwr_good = 1'b0;
        cfg_rst_n = 1'b0;
        wait_clk(10);
        chk("R8 power loss clears all", 5'b00000);
        pwr_good = 1'b1;
        wait_clk(WIN + 20);
        i2c_key(1'b1, 4, 32'hA4C6F48A);
        chk("R4 i2c key after window", 5'b00000);
        spi_frame({24'h0, 8'h00, 32'hA4C6F48A}, 5);
        chk("R4 spi key after window", 5'b00000);
        cfg_rst_n = 1'b1; wait_clk(6);
        chk("R4 late key leads to boot", 5'b00100);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; pwr_good = 1'b1; cfg_rst_n = 1'b0;
        spi_sck = 1'b0; spi_csn = 1'b1; spi_mosi = 1'b0;
        i2c_addr_hit = 1'b0; i2c_byte_vld = 1'b0; i2c_byte = 8'h00; i2c_stop = 1'b0;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(4);
        t_reset();
        t_spi_rejects();
        t_i2c_rejects();
        t_spi_multi_dummy();
        t_i2c_ok();
        t_lockout();
        t_boot();
        t_window();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule